// File: doc/BRIEF.md
# Neighbor-Linked Register Bank

A block of word storage that sits between two adjacent processing engines of a chain. It works in one of two ways. In forwarding mode the upstream engine writes and the downstream engine reads, so a pipeline stage can hand its context to the next stage. A word written on one clock edge can be read right after that edge. In local mode the downstream engine both writes and reads the storage, which then serves as extra general-purpose registers. A mode input decides which of the two write sources owns the bank. Writes from the other source are dropped.

Either writer can address a word directly by index. It can also append a word at a tail pointer (put). The reading engine can remove the word at a head pointer (get). With these two operations the same storage works as a FIFO that has full and empty flags. A put into a full bank or a get from an empty bank is refused, and either one sets an error flag that stays set until reset. When the read index matches the word being written in the same cycle, the read port returns the new data.

Top module: `nnb_bank`

## Requirements
- R1: The bank holds 128 words of 32 bits. Any index from 0 to 127 can be written and read back.
- R2: When `mode_local`=0 (forwarding), an indexed write on the `fwd_` port stores the word, and the `rd_` port returns it.
- R3: When `mode_local`=1 (local), an indexed write on the `loc_` port stores the word, and the `rd_` port returns it.
- R4: A write from the source that does not own the bank has no effect. In forwarding mode that is the `loc_` port, and in local mode it is the `fwd_` port.
- R5: A word written on a clock edge appears on `rd_data` in the cycle right after that edge, with no extra latency.
- R6: When `rd_idx` equals the target of an accepted write in the same cycle, `rd_data` returns the data being written (write-first).
- R7: A put (`*_wr_put`=1) stores the data at the tail pointer and advances the tail. A get (`get_en`) advances the head. `get_data` always shows the word at the head. Both pointers start at 0 and wrap from 127 to 0, so words come out in the order they were put.
- R8: `empty` is 1 when no words are queued. `full` is 1 after 128 more puts than gets.
- R9: A put while `full` is 1 changes no stored word and no pointer, and a get while `empty` is 1 changes no pointer. Both refused operations set `err`.
- R10: Once `err` is 1 it stays 1 until reset.
- R11: A synchronous active-low reset sets `empty`=1, `full`=0, `err`=0 and both pointers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_local | input | 1 | 0: upstream port owns writes; 1: local port owns writes |
| fwd_wr_en | input | 1 | Upstream write request |
| fwd_wr_put | input | 1 | Upstream request is a put at the tail (index ignored) |
| fwd_wr_idx | input | 7 | Upstream write index |
| fwd_wr_data | input | 32 | Upstream write data |
| loc_wr_en | input | 1 | Local write request |
| loc_wr_put | input | 1 | Local request is a put at the tail (index ignored) |
| loc_wr_idx | input | 7 | Local write index |
| loc_wr_data | input | 32 | Local write data |
| rd_idx | input | 7 | Read index of the reading engine |
| rd_data | output | 32 | Word at `rd_idx`, write-first |
| get_en | input | 1 | Remove the word at the head |
| get_data | output | 32 | Word at the head |
| full | output | 1 | All 128 words are queued |
| empty | output | 1 | No words are queued |
| err | output | 1 | Sticky flag for a refused put or get |

## Verification
On every cycle the assertions check that refused puts and gets leave the pointers untouched, that the queued count moves by at most one, that the error flag never clears on its own, that each accepted write lands in the addressed word, and that writes from the non-owning source never reach storage. Only the bench scenarios can show the end-to-end behaviour: FIFO ordering across the pointer wrap, the exact point where the bank becomes full, that a refused put keeps the old word visible on the read port, and the same-cycle write-first result.

// File: rtl/nnb_pkg.sv
// Package: shared sizes and the mode encoding for the neighbor-linked bank.
// Assumes: the depth is at least 2.
package nnb_pkg;
    parameter int unsigned NNB_WIDTH = 32;
    parameter int unsigned NNB_DEPTH = 128;

    // Which write source owns the bank.
    typedef enum logic {
        MODE_FWD   = 1'b0,
        MODE_LOCAL = 1'b1
    } nnb_mode_e;
endpackage

// File: rtl/nnb_wr_sel.sv
// Module: nnb_wr_sel
// Picks the write request of the source that currently owns the bank and drops the other one.
// Assumes: the mode is steady around any write the caller cares about.
module nnb_wr_sel
    import nnb_pkg::*;
#(
    parameter int unsigned WIDTH = NNB_WIDTH,
    parameter int unsigned IDX_W = 7
) (
    input  nnb_mode_e          mode,
    input  logic               fwd_en,
    input  logic               fwd_put,
    input  logic [IDX_W-1:0]   fwd_idx,
    input  logic [WIDTH-1:0]   fwd_data,
    input  logic               loc_en,
    input  logic               loc_put,
    input  logic [IDX_W-1:0]   loc_idx,
    input  logic [WIDTH-1:0]   loc_data,
    output logic               sel_en,
    output logic               sel_put,
    output logic [IDX_W-1:0]   sel_idx,
    output logic [WIDTH-1:0]   sel_data
);
    // Route the owning source; the foreign source never raises sel_en.
    always_comb begin
        if (mode == MODE_LOCAL) begin
            sel_en   = loc_en;
            sel_put  = loc_put;
            sel_idx  = loc_idx;
            sel_data = loc_data;
        end else begin
            sel_en   = fwd_en;
            sel_put  = fwd_put;
            sel_idx  = fwd_idx;
            sel_data = fwd_data;
        end
    end
endmodule

// File: rtl/nnb_ring_ctl.sv
// Module: nnb_ring_ctl
// Keeps the head and tail pointers, the queued count, the full/empty flags and the sticky error
// for put/get use of the bank. Decisions are made on the state before the edge: a put while full
// is refused even if a get happens in the same cycle, and the same holds for a get while empty.
// Assumes: synchronous active-low reset.
module nnb_ring_ctl #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned IDX_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             put_req,
    input  logic             get_req,
    output logic             put_ok,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty,
    output logic             err
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [CNT_W-1:0] count;
    logic             get_ok;

    // Advance a pointer with wrap at the last index.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Accept or refuse the requests based on the current flags.
    always_comb begin
        full   = (count == FULL_CNT);
        empty  = (count == '0);
        put_ok = put_req && !full;
        get_ok = get_req && !empty;
    end

    // Move the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (put_ok) tail <= bump(tail);
            if (get_ok) head <= bump(head);
            if (put_ok && !get_ok)      count <= count + 1'b1;
            else if (get_ok && !put_ok) count <= count - 1'b1;
        end
    end

    // Set the sticky error on any refused request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      err <= 1'b0;
        else if ((put_req && full) || (get_req && empty)) err <= 1'b1;
    end

    // R9: a refused put leaves the tail where it was.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && put_req) |=> (tail == $past(tail)));
    // R9: a refused get leaves the head where it was.
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && get_req) |=> (head == $past(head)));
    // R10: the error flag holds until reset.
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R8: the queued count moves by at most one per cycle.
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
                   || (count == $past(count) - 1'b1)));
endmodule

// File: rtl/nnb_store.sv
// Module: nnb_store
// Word storage with one write port and two combinational read ports. The indexed read port is
// write-first: a read that matches the word being written in the same cycle returns the new data.
// Assumes: storage is not reset; only the control state is.
module nnb_store #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata,
    input  logic [IDX_W-1:0] haddr,
    output logic [WIDTH-1:0] hdata
);
    logic [WIDTH-1:0] words [DEPTH];

    // One write-enabled register per word.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Capture the write data when this word is addressed.
        always_ff @(posedge clk) begin
            if (we && (waddr == IDX_W'(g))) words[g] <= wdata;
        end
    end

    // Indexed read with write-first bypass; head read straight from storage.
    always_comb begin
        rdata = (we && (waddr == raddr)) ? wdata : words[raddr];
        hdata = words[haddr];
    end

    // R5: an accepted write is in the addressed word one edge later.
    a_r5_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (words[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/nnb_bank.sv
// Module: nnb_bank
// Top of the neighbor-linked register bank. Selects the owning writer, turns a put into a write at
// the tail when the ring controller accepts it, and exposes indexed and head reads.
// Assumes: synchronous active-low reset; mode_local changes only between transfers.
module nnb_bank
    import nnb_pkg::*;
#(
    parameter int unsigned WIDTH = NNB_WIDTH,
    parameter int unsigned DEPTH = NNB_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_local,
    input  logic             fwd_wr_en,
    input  logic             fwd_wr_put,
    input  logic [IDX_W-1:0] fwd_wr_idx,
    input  logic [WIDTH-1:0] fwd_wr_data,
    input  logic             loc_wr_en,
    input  logic             loc_wr_put,
    input  logic [IDX_W-1:0] loc_wr_idx,
    input  logic [WIDTH-1:0] loc_wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data,
    input  logic             get_en,
    output logic [WIDTH-1:0] get_data,
    output logic             full,
    output logic             empty,
    output logic             err
);
    nnb_mode_e        mode;
    logic             sel_en;
    logic             sel_put;
    logic [IDX_W-1:0] sel_idx;
    logic [WIDTH-1:0] sel_data;
    logic             put_ok;
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic             st_we;
    logic [IDX_W-1:0] st_addr;

    // Decode the mode input into the shared enum.
    always_comb mode = nnb_mode_e'(mode_local);

    nnb_wr_sel #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_sel (
        .mode    (mode),
        .fwd_en  (fwd_wr_en),
        .fwd_put (fwd_wr_put),
        .fwd_idx (fwd_wr_idx),
        .fwd_data(fwd_wr_data),
        .loc_en  (loc_wr_en),
        .loc_put (loc_wr_put),
        .loc_idx (loc_wr_idx),
        .loc_data(loc_wr_data),
        .sel_en  (sel_en),
        .sel_put (sel_put),
        .sel_idx (sel_idx),
        .sel_data(sel_data)
    );

    nnb_ring_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .put_req(sel_en && sel_put),
        .get_req(get_en),
        .put_ok (put_ok),
        .head   (head),
        .tail   (tail),
        .full   (full),
        .empty  (empty),
        .err    (err)
    );

    // Form the storage write: indexed writes always, puts only when accepted.
    always_comb begin
        st_we   = sel_en && (!sel_put || put_ok);
        st_addr = sel_put ? tail : sel_idx;
    end

    nnb_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (st_we),
        .waddr(st_addr),
        .wdata(sel_data),
        .raddr(rd_idx),
        .rdata(rd_data),
        .haddr(head),
        .hdata(get_data)
    );

    // R4: in local mode a lone upstream write never reaches storage.
    a_r4_fwd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_local && fwd_wr_en && !loc_wr_en) |-> !st_we);
    // R4: in forwarding mode a lone local write never reaches storage.
    a_r4_loc_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_local && loc_wr_en && !fwd_wr_en) |-> !st_we);
    // R9: a put into a full bank writes nothing.
    a_r9_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (full && sel_en && sel_put) |-> !st_we);
endmodule

// File: tb/nnb_bank_test.sv
module nnb_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_local = 1'b0;
    logic        fwd_wr_en = 1'b0, fwd_wr_put = 1'b0;
    logic [6:0]  fwd_wr_idx = '0;
    logic [31:0] fwd_wr_data = '0;
    logic        loc_wr_en = 1'b0, loc_wr_put = 1'b0;
    logic [6:0]  loc_wr_idx = '0;
    logic [31:0] loc_wr_data = '0;
    logic [6:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        get_en = 1'b0;
    logic [31:0] get_data;
    logic        full, empty, err;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];

    nnb_bank uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    task automatic fwd_write(logic [6:0] i, logic [31:0] d);
        fwd_wr_en = 1'b1; fwd_wr_put = 1'b0; fwd_wr_idx = i; fwd_wr_data = d;
        tick(); fwd_wr_en = 1'b0;
    endtask

    task automatic loc_write(logic [6:0] i, logic [31:0] d);
        loc_wr_en = 1'b1; loc_wr_put = 1'b0; loc_wr_idx = i; loc_wr_data = d;
        tick(); loc_wr_en = 1'b0;
    endtask

    task automatic read_chk(string req, logic [6:0] i, logic [31:0] exp);
        rd_idx = i; #1; check(req, rd_data, exp);
    endtask

    // Driver: a put from the upstream port pushes the expected word when accepted.
    task automatic put(logic [31:0] d, bit expect_accept);
        fwd_wr_en = 1'b1; fwd_wr_put = 1'b1; fwd_wr_data = d;
        if (expect_accept) exp_q.push_back(d);
        tick(); fwd_wr_en = 1'b0; fwd_wr_put = 1'b0;
    endtask

    // Monitor: compare the head word to the scoreboard, then remove it.
    task automatic get(string req);
        logic [31:0] e;
        #1;
        e = exp_q.pop_front();
        check(req, get_data, e);
        get_en = 1'b1; tick(); get_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R11 reset state
        check("R11 empty", {31'd0, empty}, 32'd1);
        check("R11 full", {31'd0, full}, 32'd0);
        check("R11 err", {31'd0, err}, 32'd0);

        // R1 R2 R5: forwarding writes at both ends of the index range
        fwd_write(7'd0, 32'h1111_0000);
        read_chk("R5 R2 idx0 next cycle", 7'd0, 32'h1111_0000);
        fwd_write(7'd127, 32'h7F7F_7F7F);
        read_chk("R1 idx127", 7'd127, 32'h7F7F_7F7F);

        // R4: local writes ignored in forwarding mode
        fwd_write(7'd5, 32'hAAAA_0005);
        loc_write(7'd5, 32'hBBBB_0005);
        read_chk("R4 loc ignored fwd mode", 7'd5, 32'hAAAA_0005);

        // R6: same-cycle read of the word being written
        fwd_wr_en = 1'b1; fwd_wr_put = 1'b0; fwd_wr_idx = 7'd9; fwd_wr_data = 32'hC0DE_0009;
        rd_idx = 7'd9; #1;
        check("R6 write-first", rd_data, 32'hC0DE_0009);
        tick(); fwd_wr_en = 1'b0;
        read_chk("R6 stored after", 7'd9, 32'hC0DE_0009);

        // R3 R4: local mode
        mode_local = 1'b1;
        loc_write(7'd20, 32'h2020_2020);
        read_chk("R3 local readback", 7'd20, 32'h2020_2020);
        fwd_write(7'd20, 32'hDEAD_BEEF);
        read_chk("R4 fwd ignored local mode", 7'd20, 32'h2020_2020);
        mode_local = 1'b0;

        // R7: basic FIFO order
        for (int k = 0; k < 3; k++) put(32'h5000_0000 + k, 1'b1);
        check("R8 not empty", {31'd0, empty}, 32'd0);
        for (int k = 0; k < 3; k++) get("R7 order");
        check("R8 drained empty", {31'd0, empty}, 32'd1);
        check("R10 err clear", {31'd0, err}, 32'd0);

        // R8: fill all words (tail wraps from 127 to 0)
        for (int k = 0; k < DEPTH; k++) put(32'h6000_0000 + k, 1'b1);
        check("R8 full", {31'd0, full}, 32'd1);
        // R9: put while full is refused; head at index 3 keeps its word
        put(32'hFFFF_FFFF, 1'b0);
        read_chk("R9 full put no write", 7'd3, 32'h6000_0000);
        check("R9 err on full put", {31'd0, err}, 32'd1);
        check("R9 still full", {31'd0, full}, 32'd1);

        // R7: drain in order across the wrap
        for (int k = 0; k < DEPTH; k++) get("R7 wrap order");
        check("R8 empty after drain", {31'd0, empty}, 32'd1);
        check("R10 err still set", {31'd0, err}, 32'd1);

        // R9 R10: get on empty after a fresh reset
        do_reset();
        check("R11 err cleared", {31'd0, err}, 32'd0);
        get_en = 1'b1; tick(); get_en = 1'b0;
        check("R9 err on empty get", {31'd0, err}, 32'd1);
        check("R9 still empty", {31'd0, empty}, 32'd1);
        put(32'h7777_0001, 1'b1);
        get("R9 head unmoved");
        tick();
        check("R10 err holds", {31'd0, err}, 32'd1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule